// File: doc/BRIEF.md
# SPI Master Frame Transfer Engine

This block sequences transfers for a register-mapped SPI master. When it is enabled and has frames left in its count, it takes one word at a time from an external transmit queue. It shifts the word out most-significant bit first as a frame of 1 to 32 bits in SPI mode 0 and collects the bits coming back on the input pin. It then hands the received word, right-aligned, to an external receive queue. A programmable frame count sets how many frames make up one burst. When a burst ends, the count reloads itself from the control register, so another burst can follow without a new control write.

The chip select is driven automatically and is active low. A mode bit chooses how it behaves. In hold mode the select goes low for the first frame and stays low until the last frame of the count has finished. In pulse mode it returns high after each frame. The block keeps the transfer-complete, receive-ready and overflow flags in two forms: a status view and a latched raw-interrupt view. The FIFOs and interrupt masking sit outside this block. The control, frame-size and clock-divider registers are held here, and a self-clearing soft reset is available through the control register.

Top module: `spi_frame_engine`

## Requirements
- R1: After `rst`, `ctrl_q` reads 0x80000102, `fsz_q` reads 4 and `div_q` reads 7. `cs_n` is high and `irq_raw` is 0. `status` reads 0x2440 while both queues report empty. Status bit positions: 0 done, 1 receive-ready, 2 overflow, 6 receive queue empty, 10 transmit queue empty, 13 select high, 14 active.
- R2: A frame starts only when control bit 0 (enable) is 1, `tx_empty` is 0 and the remaining frame count is nonzero. `tx_pop` pulses for one cycle, in the cycle after the frame starts.
- R3: A frame shifts exactly N bits, where N is `fsz_q` (a value of 0 counts as 1). The first bit on `mosi` is bit N-1 of the word. `sclk` idles low, `miso` is sampled on each rising edge of `sclk`, and `mosi` changes on falling edges. Each `sclk` level lasts `div_q`+1 clocks, so `status[14]` stays high for 2*N*(`div_q`+1) clocks. The received word is right-aligned, with the first bit sampled as its bit N-1.
- R4: Every write to control loads the remaining count from control bits [23:8]. Each finished frame lowers the count by one. When the count reaches zero it reloads from control bits [23:8].
- R5: With control bit 26 set, `cs_n` falls at the first frame and stays low between frames. It returns high only after the frame that brings the count to zero.
- R6: With control bit 26 clear, `cs_n` returns high after every frame.
- R7: Status bits 0 and 1 clear when a frame starts. When the count reaches zero, bits 0 and 1 are set in both `status` and `irq_raw`.
- R8: When a frame finishes and `rx_full` is 0, `rx_push` pulses with the received word on `rx_data`. When `rx_full` is 1, the word is dropped, no push occurs, and bit 2 is set in both `status` and `irq_raw`.
- R9: A frame-size write is ignored if control bit 0 is set or if the value is greater than 32. Otherwise it is stored.
- R10: Each set bit of `flag_clr` clears the `irq_raw` bit at the same position and leaves `status` unchanged. `rx_read` clears status bit 2.
- R11: Status bit 14 is high exactly while a frame is shifting. Status bit 13 follows `cs_n`.
- R12: A control write with bit 31 set returns every register, flag, count and the select to the R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control write value |
| fsz_wr | input | 1 | Frame-size write strobe |
| fsz_wdata | input | 6 | Frame-size write value |
| div_wr | input | 1 | Clock-divider write strobe |
| div_wdata | input | DIV_W | Clock-divider write value |
| flag_clr | input | 3 | Per-bit clear of raw interrupt flags |
| rx_read | input | 1 | Receive queue read by software, clears overflow status |
| tx_empty | input | 1 | Transmit queue empty |
| tx_data | input | WORD_W | Head word of the transmit queue |
| tx_pop | output | 1 | Remove head word from the transmit queue |
| rx_full | input | 1 | Receive queue full |
| rx_empty | input | 1 | Receive queue empty |
| rx_push | output | 1 | Write `rx_data` into the receive queue |
| rx_data | output | WORD_W | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| ctrl_q | output | 32 | Control register |
| fsz_q | output | 6 | Frame-size register |
| div_q | output | DIV_W | Clock-divider register |
| status | output | 15 | Status word |
| irq_raw | output | 3 | Raw interrupt flags: done, receive-ready, overflow |

## Verification
The bench walks frame sizes from 1 to 32 at several divider settings. For each one it checks the bit order, the alignment of the received word and the exact number of active clocks, which catches off-by-one bit counters and LSB-first shifting. Hold-mode bursts are split across a count reload to show that the select stays low across the gap, and that done stays low until the reloaded count runs out. A design that reloaded on every frame, or raised the select when the queue went empty, would fail those checks. The other directed cases are a full receive queue, rejected frame-size writes, a zero frame count, flag clearing that must not touch status, and soft reset. They catch a design that pushes into a full queue, that honours a write while enabled, or that starts frames with no count left.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int CTRL_W        = 32;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 32'h8000_0102;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CNT_LSB  = 8;
  localparam int CTRL_HOLD_BIT = 26;
  localparam int CTRL_SRST_BIT = 31;

  localparam int FSZ_W         = 6;
  localparam int FSZ_RESET     = 4;
  localparam int DIV_RESET     = 7;

  localparam int STATUS_W      = 15;
  localparam int FLAG_W        = 3;
  localparam int ST_DONE       = 0;
  localparam int ST_RXRDY      = 1;
  localparam int ST_OVF        = 2;
  localparam int ST_RXEMP      = 6;
  localparam int ST_TXEMP      = 10;
  localparam int ST_SEL        = 13;
  localparam int ST_ACT        = 14;
endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_eng_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              fsz_wr,
  input  logic [FSZ_W-1:0]  fsz_wdata,
  input  logic              div_wr,
  input  logic [DIV_W-1:0]  div_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [FSZ_W-1:0]  fsz_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              soft_rst
);
  localparam logic [FSZ_W-1:0] FSZ_MAX = FSZ_W'(WORD_W);

  logic fsz_ok;

  assign soft_rst = ctrl_wr & ctrl_wdata[CTRL_SRST_BIT];
  assign fsz_ok   = fsz_wr && !ctrl_q[CTRL_EN_BIT] && (fsz_wdata <= FSZ_MAX);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctrl_q <= CTRL_RESET;
      fsz_q  <= FSZ_W'(FSZ_RESET);
      div_q  <= DIV_W'(DIV_RESET);
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_wdata;
      if (fsz_ok)  fsz_q  <= fsz_wdata;
      if (div_wr)  div_q  <= div_wdata;
    end
  end

  // R9: stored frame size never exceeds the word width
  assert_fsz_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    fsz_q <= FSZ_MAX);

  // R9: writes while enabled leave the frame size alone
  assert_fsz_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (fsz_wr && ctrl_q[CTRL_EN_BIT] && !soft_rst) |=> $stable(fsz_q));
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic [LEN_W-1:0]  nbits,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] sh_tx;
  logic [DIV_W-1:0]  half_cnt;
  logic [LEN_W-1:0]  bits_left;
  logic [LEN_W:0]    align;

  assign align = (LEN_W+1)'(WORD_W) - {1'b0, nbits};
  assign mosi  = sh_tx[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_tx     <= '0;
      rx_word   <= '0;
      half_cnt  <= '0;
      bits_left <= '0;
      sclk      <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          sh_tx     <= word << align;
          rx_word   <= '0;
          bits_left <= nbits;
          half_cnt  <= '0;
          sclk      <= 1'b0;
          busy      <= 1'b1;
        end
      end else if (half_cnt == div) begin
        half_cnt <= '0;
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_word <= {rx_word[WORD_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bits_left == LEN_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bits_left <= bits_left - LEN_W'(1);
            sh_tx     <= {sh_tx[WORD_W-2:0], 1'b0};
          end
        end
      end else begin
        half_cnt <= half_cnt + DIV_W'(1);
      end
    end
  end

  // R3: serial clock rests low outside a frame
  assert_sclk_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);

  // R3: a completion pulse only follows a shifting frame
  assert_done_after_shift_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_eng_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              hold_sel,
  input  logic [CNT_W-1:0]  cnt_field,
  input  logic              ctrl_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              tx_empty,
  input  logic              busy,
  input  logic              done,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_full,
  input  logic [FLAG_W-1:0] flag_clr,
  input  logic              rx_read,
  output logic              start,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  output logic              cs_n,
  output logic [FLAG_W-1:0] flags_st,
  output logic [FLAG_W-1:0] flags_raw
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign start = enable && !tx_empty && (cnt_q != '0) && !busy && !done && !tx_pop;
  assign last  = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= CNT_W'(1);
      cs_n      <= 1'b1;
      flags_st  <= '0;
      flags_raw <= '0;
      tx_pop    <= 1'b0;
      rx_push   <= 1'b0;
      rx_data   <= '0;
    end else begin
      tx_pop  <= start;
      rx_push <= 1'b0;
      flags_raw <= flags_raw & ~flag_clr;
      if (rx_read) flags_st[ST_OVF] <= 1'b0;
      if (start) begin
        cs_n                 <= 1'b0;
        flags_st[ST_DONE]    <= 1'b0;
        flags_st[ST_RXRDY]   <= 1'b0;
      end
      if (done) begin
        if (rx_full) begin
          flags_st[ST_OVF]  <= 1'b1;
          flags_raw[ST_OVF] <= 1'b1;
        end else begin
          rx_push <= 1'b1;
          rx_data <= rx_word;
        end
        if (last) begin
          cnt_q               <= cnt_field;
          cs_n                <= 1'b1;
          flags_st[ST_DONE]   <= 1'b1;
          flags_st[ST_RXRDY]  <= 1'b1;
          flags_raw[ST_DONE]  <= 1'b1;
          flags_raw[ST_RXRDY] <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (!hold_sel) cs_n <= 1'b1;
        end
      end
      if (ctrl_wr) cnt_q <= cnt_wdata;
    end
  end

  // R2: the queue pop follows the frame start by one cycle
  assert_pop_follows_start_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> tx_pop);

  // R8: a full receive queue never receives a push
  assert_no_push_when_full_R8: assert property (@(posedge clk) disable iff (rst)
    (done && rx_full) |=> !rx_push);

  // R7: the last frame of a burst raises done and releases the select
  assert_last_frame_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (done && cnt_q == CNT_W'(1) && !ctrl_wr) |=> (flags_raw[ST_DONE] && flags_st[ST_DONE] && cs_n));
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_eng_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [31:0]       ctrl_wdata,
  input  logic              fsz_wr,
  input  logic [5:0]        fsz_wdata,
  input  logic              div_wr,
  input  logic [DIV_W-1:0]  div_wdata,
  input  logic [2:0]        flag_clr,
  input  logic              rx_read,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  input  logic              rx_empty,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n,
  output logic [31:0]       ctrl_q,
  output logic [5:0]        fsz_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [14:0]       status,
  output logic [2:0]        irq_raw
);
  localparam int LEN_W = $clog2(WORD_W + 1);

  logic              soft_rst;
  logic              rst_all;
  logic              start;
  logic              busy;
  logic              done;
  logic [WORD_W-1:0] rx_word;
  logic [LEN_W-1:0]  nbits;
  logic [FLAG_W-1:0] flags_st;

  assign rst_all = rst | soft_rst;
  assign nbits   = (fsz_q == '0) ? LEN_W'(1) : LEN_W'(fsz_q);

  spi_cfg_regs #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst(rst),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .fsz_wr(fsz_wr), .fsz_wdata(fsz_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata),
    .ctrl_q(ctrl_q), .fsz_q(fsz_q), .div_q(div_q),
    .soft_rst(soft_rst)
  );

  spi_shift_unit #(.WORD_W(WORD_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst_all), .start(start), .word(tx_data),
    .nbits(nbits), .div(div_q), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(busy), .done(done), .rx_word(rx_word)
  );

  spi_frame_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst_all),
    .enable(ctrl_q[CTRL_EN_BIT]),
    .hold_sel(ctrl_q[CTRL_HOLD_BIT]),
    .cnt_field(ctrl_q[CTRL_CNT_LSB +: CNT_W]),
    .ctrl_wr(ctrl_wr),
    .cnt_wdata(ctrl_wdata[CTRL_CNT_LSB +: CNT_W]),
    .tx_empty(tx_empty), .busy(busy), .done(done), .rx_word(rx_word),
    .rx_full(rx_full), .flag_clr(flag_clr), .rx_read(rx_read),
    .start(start), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .cs_n(cs_n), .flags_st(flags_st), .flags_raw(irq_raw)
  );

  always_comb begin
    status           = '0;
    status[ST_DONE]  = flags_st[ST_DONE];
    status[ST_RXRDY] = flags_st[ST_RXRDY];
    status[ST_OVF]   = flags_st[ST_OVF];
    status[ST_RXEMP] = rx_empty;
    status[ST_TXEMP] = tx_empty;
    status[ST_SEL]   = cs_n;
    status[ST_ACT]   = busy;
  end

  // R11: the select is low for the whole of every shifting frame
  assert_cs_low_in_frame_R11: assert property (@(posedge clk) disable iff (rst_all)
    busy |-> !cs_n);
endmodule

// File: tb/sim_spi_frame_engine.sv
module sim_spi_frame_engine;
  localparam int CLK_P  = 10;
  localparam int WORD_W = 32;
  localparam int DIV_W  = 8;

  typedef struct packed {
    logic [5:0]  fsz;
    logic [7:0]  div;
    logic [31:0] tx;
    logic [31:0] rx;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{fsz: 6'd8,  div: 8'd0, tx: 32'h0000_00A5, rx: 32'h0000_003C},
    '{fsz: 6'd1,  div: 8'd0, tx: 32'h0000_0001, rx: 32'h0000_0001},
    '{fsz: 6'd32, div: 8'd0, tx: 32'hDEAD_BEEF, rx: 32'h1234_5678},
    '{fsz: 6'd16, div: 8'd2, tx: 32'h5555_ABCD, rx: 32'h0000_F00F},
    '{fsz: 6'd5,  div: 8'd1, tx: 32'hFFFF_FF13, rx: 32'h0000_000A},
    '{fsz: 6'd12, div: 8'd3, tx: 32'h0000_0C35, rx: 32'hABCD_E9A6}
  };

  logic clk = 0, rst = 1;
  logic ctrl_wr = 0, fsz_wr = 0, div_wr = 0, rx_read = 0;
  logic [31:0] ctrl_wdata = 0;
  logic [5:0]  fsz_wdata = 0;
  logic [DIV_W-1:0] div_wdata = 0;
  logic [2:0]  flag_clr = 0;
  logic tx_empty, tx_pop, rx_full = 0, rx_empty = 1, rx_push;
  logic [WORD_W-1:0] tx_data, rx_data;
  logic sclk, mosi, miso, cs_n;
  logic [31:0] ctrl_q;
  logic [5:0]  fsz_q;
  logic [DIV_W-1:0] div_q;
  logic [14:0] status;
  logic [2:0]  irq_raw;

  logic [31:0] tx_mem [16];
  logic [3:0]  rp = 0, wp = 0;
  logic [31:0] miso_word = 0, mosi_cap = 0, last_rx = 0;
  logic [5:0]  sidx = 0;
  int n_push = 0, n_rise = 0, n_csrise = 0, n_act = 0;
  int n_chk = 0, n_fail = 0;

  assign tx_empty = (rp == wp);
  assign tx_data  = tx_mem[rp];
  assign miso     = miso_word[sidx[4:0]];

  always #(CLK_P/2) clk = ~clk;

  spi_frame_engine #(.WORD_W(WORD_W), .DIV_W(DIV_W), .CNT_W(16)) u0 (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .fsz_wr(fsz_wr), .fsz_wdata(fsz_wdata), .div_wr(div_wr), .div_wdata(div_wdata),
    .flag_clr(flag_clr), .rx_read(rx_read), .tx_empty(tx_empty), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_full(rx_full), .rx_empty(rx_empty), .rx_push(rx_push),
    .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .ctrl_q(ctrl_q), .fsz_q(fsz_q), .div_q(div_q), .status(status), .irq_raw(irq_raw)
  );

  always @(posedge clk) begin
    if (tx_pop) rp <= rp + 4'd1;
    if (rx_push) begin last_rx <= rx_data; n_push <= n_push + 1; end
    if (status[14]) n_act <= n_act + 1;
  end

  always @(posedge sclk) begin
    mosi_cap <= {mosi_cap[30:0], mosi};
    sidx     <= sidx - 6'd1;
    n_rise   <= n_rise + 1;
  end

  always @(posedge cs_n) n_csrise <= n_csrise + 1;

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic w_ctrl(input logic [31:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic w_fsz(input logic [5:0] v);
    @(negedge clk); fsz_wr = 1; fsz_wdata = v;
    @(negedge clk); fsz_wr = 0;
  endtask

  task automatic w_div(input logic [7:0] v);
    @(negedge clk); div_wr = 1; div_wdata = v;
    @(negedge clk); div_wr = 0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); tx_mem[wp] = w; wp = wp + 4'd1;
  endtask

  task automatic clear_counts();
    @(negedge clk); n_push = 0; n_rise = 0; n_csrise = 0; n_act = 0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 5000 && quiet < 4; i++) begin
      @(negedge clk);
      if (tx_empty && !status[14] && !tx_pop) quiet++; else quiet = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x1 expected=0x0");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrl_q, 32'h8000_0102);
    chk("R1 fsz", 32'(fsz_q), 32'd4);
    chk("R1 div", 32'(div_q), 32'd7);
    chk("R1 status", 32'(status), 32'h2440);
    chk("R1 cs_n", 32'(cs_n), 32'd1);
    chk("R1 irq_raw", 32'(irq_raw), 32'd0);

    // R2: enabled but empty queue, zero count, disabled
    clear_counts();
    w_ctrl(32'h0000_0101);
    repeat (20) @(negedge clk);
    chk("R2 no start empty queue", 32'(status[14]), 32'd0);
    w_ctrl(32'h0000_0001);
    push(32'h0000_0009);
    repeat (20) @(negedge clk);
    chk("R2 zero count no start", {31'd0, tx_empty}, 32'd0);
    chk("R2 zero count no sclk", n_rise, 32'd0);
    w_ctrl(32'h0000_0100);
    repeat (20) @(negedge clk);
    chk("R2 disabled no start", {31'd0, tx_empty}, 32'd0);
    w_ctrl(32'h0000_0101);
    wait_idle();
    chk("R2 frame ran after enable", n_push, 32'd1);

    // R3 vector table walk
    for (int i = 0; i < 6; i++) begin
      int n;
      logic [31:0] m;
      n = (VEC[i].fsz == 0) ? 1 : int'(VEC[i].fsz);
      m = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
      w_ctrl(32'h0000_0100);
      w_fsz(VEC[i].fsz);
      w_div(VEC[i].div);
      @(negedge clk);
      miso_word = VEC[i].rx; sidx = 6'(n - 1); mosi_cap = 0;
      clear_counts();
      push(VEC[i].tx);
      w_ctrl(32'h0000_0101);
      wait_idle();
      chk($sformatf("R3 mosi bits vec%0d", i), mosi_cap & m, VEC[i].tx & m);
      chk($sformatf("R3 rx word vec%0d", i), last_rx, VEC[i].rx & m);
      chk($sformatf("R3 sclk rises vec%0d", i), n_rise, n);
      chk($sformatf("R11 active clocks vec%0d", i), n_act, 2 * n * (int'(VEC[i].div) + 1));
      chk($sformatf("R7 done set vec%0d", i), 32'(status[0]), 32'd1);
    end

    // R9 frame-size write rules
    w_ctrl(32'h0000_0100);
    w_fsz(6'd33);
    chk("R9 oversize rejected", 32'(fsz_q), 32'd12);
    w_ctrl(32'h0000_0101);
    w_fsz(6'd8);
    chk("R9 locked while enabled", 32'(fsz_q), 32'd12);
    w_ctrl(32'h0000_0100);
    w_fsz(6'd32);
    chk("R9 max accepted", 32'(fsz_q), 32'd32);
    w_fsz(6'd4);
    w_div(8'd0);

    // R5 hold mode burst of three
    w_ctrl(32'h0400_0301);
    clear_counts();
    push(32'h1); push(32'h2); push(32'h3);
    wait_idle();
    chk("R5 single select release", n_csrise, 32'd1);
    chk("R5 three frames pushed", n_push, 32'd3);
    chk("R7 raw done and ready", 32'(irq_raw[1:0]), 32'd3);
    chk("R5 select high after burst", 32'(cs_n), 32'd1);

    // R4 reload: two of three frames, select must stay low
    clear_counts();
    push(32'h4); push(32'h5);
    wait_idle();
    chk("R4 partial burst no done", 32'(status[0]), 32'd0);
    chk("R5 select held across gap", 32'(cs_n), 32'd0);
    chk("R11 select status follows pin", 32'(status[13]), 32'd0);
    push(32'h6);
    wait_idle();
    chk("R4 reloaded count finishes", 32'(status[0]), 32'd1);
    chk("R5 select released once", n_csrise, 32'd1);

    // R6 pulse mode, count two
    w_ctrl(32'h0000_0201);
    clear_counts();
    push(32'h7); push(32'h8);
    wait_idle();
    chk("R6 select pulses per frame", n_csrise, 32'd2);
    chk("R4 count two done", 32'(status[0]), 32'd1);

    // R10 raw clear leaves status
    @(negedge clk); flag_clr = 3'b011;
    @(negedge clk); flag_clr = 3'b000;
    chk("R10 raw cleared", 32'(irq_raw), 32'd0);
    chk("R10 status kept", 32'(status[1:0]), 32'd3);

    // R7 flags clear at frame start
    push(32'h9);
    for (int i = 0; i < 50 && !status[14]; i++) @(negedge clk);
    chk("R7 done cleared at start", 32'(status[1:0]), 32'd0);
    chk("R11 active during frame", 32'(status[14]), 32'd1);
    wait_idle();
    push(32'hA);
    wait_idle();

    // R8 overflow
    rx_full = 1;
    clear_counts();
    push(32'hB);
    wait_idle();
    chk("R8 no push when full", n_push, 32'd0);
    chk("R8 overflow status", 32'(status[2]), 32'd1);
    chk("R8 overflow raw", 32'(irq_raw[2]), 32'd1);
    @(negedge clk); flag_clr = 3'b100;
    @(negedge clk); flag_clr = 3'b000;
    chk("R10 raw overflow cleared", 32'(irq_raw[2]), 32'd0);
    chk("R10 status overflow kept", 32'(status[2]), 32'd1);
    @(negedge clk); rx_read = 1;
    @(negedge clk); rx_read = 0;
    chk("R10 rx read clears overflow", 32'(status[2]), 32'd0);
    rx_full = 0;

    // R12 soft reset
    w_div(8'd3);
    w_ctrl(32'h8000_0000);
    chk("R12 ctrl", ctrl_q, 32'h8000_0102);
    chk("R12 fsz", 32'(fsz_q), 32'd4);
    chk("R12 div", 32'(div_q), 32'd7);
    chk("R12 status", 32'(status), 32'h2440);
    chk("R12 irq_raw", 32'(irq_raw), 32'd0);

    report();
  end
endmodule